// File: doc/BRIEF.md
# Processor Tick Timer

The block is a tick timer that sits beside a processor core. It divides the system clock down to a timer tick. On every tick it advances a 32-bit count register, and it compares the low 28 bits of that count against a programmable period. When the comparison hits, the timer can latch a pending flag and raise an interrupt line. Depending on its mode, it then clears the count, freezes it, or lets it run on.

Software controls the timer through two 32-bit registers on a flat register port: a control word and the count. A single write strobe with a one-bit address selects which register is loaded, and the read data is a combinational view of the selected register. The default prescaler divides a 200 MHz system clock by 10, which gives a 50 ns tick.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word and the count both read as zero and `irq` is low.
- R2: A tick occurs on every PRESCALE-th clock edge after reset release, the first tick on edge PRESCALE. While the timer is counting, each tick adds one to the count.
- R3: `reg_addr` 0 selects the control word and 1 selects the count. `reg_we` loads `reg_wdata` into the selected register. The control word holds the mode in bits 31:30, interrupt enable in bit 29, pending in bit 28 and the period in bits 27:0. `reg_rdata` shows the selected register.
- R4: A hit happens on a counting tick when bits 27:0 of the incremented count equal the period. Count bits 31:28 play no part in the compare.
- R5: A hit while enable is 1 sets pending. `irq` is high exactly when pending and enable are both 1. A hit with enable 0 leaves pending unchanged.
- R6: Pending stays set until a control write carries 0 in bit 28. A control write with bit 28 at 1 cannot set it. If a hit and a clearing write fall in the same cycle, pending ends up set.
- R7: In mode 01 (restart), a hit loads the count with zero instead of the incremented value.
- R8: In mode 10 (one-shot), a hit stores the incremented value and stops counting. Any control write restarts counting.
- R9: In mode 11 (free run), a hit leaves counting unaffected, so the next hit with an unchanged period comes 2^28 ticks later.
- R10: In mode 00 (off), the count holds its value and no hit occurs.
- R11: A count write takes priority over both the increment and the restart clear in the same cycle, and no hit is recorded in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control word, 1 count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Timer interrupt request |

## Verification
Two pairs of events can land on the same clock edge. A software count write can meet the tick that would increment, or restart-clear, the count. A control write that clears pending can meet a hit that sets it. The bench forces the first pair by writing the count every cycle at a value one below the period, so that every tick edge falls under a write. It forces the second pair by sliding the clearing write across every prescaler phase around a known hit. A cycle-by-cycle model built from the requirements judges both registers and `irq` after every edge, and a long randomized stretch with small periods does the same.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int REG_W = 32;
  localparam int PER_W = 28;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_FREE    = 2'b11
  } tm_mode_e;

  // control word, packed so that bit positions match the register layout
  typedef struct packed {
    tm_mode_e           mode;    // 31:30
    logic               ie;      // 29
    logic               pend;    // 28
    logic [PER_W-1:0]   period;  // 27:0
  } tm_ctrl_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PRESCALE = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] psc_q, psc_d;

      always_comb begin
        tick  = (psc_q == LAST);
        psc_d = tick ? '0 : psc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
      end
    end
  endgenerate
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  tm_mode_e          mode,
  input  logic [PER_W-1:0]  period,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  cnt_q,
  output logic              hit
);
  logic [REG_W-1:0] cnt_d, cnt_inc;
  logic             step;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    step    = tick && run;
    hit     = step && !wr_en && (cnt_inc[PER_W-1:0] == period);
    cnt_d   = cnt_q;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (step) begin
      cnt_d = (hit && mode == TM_RESTART) ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              hit,
  output tm_ctrl_t          ctrl_q,
  output logic              run
);
  tm_ctrl_t ctrl_d;
  logic     halt_q, halt_d;

  always_comb begin
    ctrl_d = ctrl_q;
    halt_d = halt_q;
    if (wr_en) begin
      ctrl_d      = tm_ctrl_t'(wr_data);
      ctrl_d.pend = wr_data[PER_W] & ctrl_q.pend;
      halt_d      = 1'b0;
    end else if (hit && ctrl_q.mode == TM_ONESHOT) begin
      halt_d = 1'b1;
    end
    if (hit && ctrl_q.ie) ctrl_d.pend = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      halt_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      halt_q <= halt_d;
    end
  end

  assign run = (ctrl_q.mode != TM_OFF) && !halt_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int PRESCALE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  tm_ctrl_t          ctrl_q;
  logic [REG_W-1:0]  cnt_q;
  logic              tick, run, hit;
  logic              wr_ctrl, wr_cnt;

  assign wr_ctrl = reg_we && !reg_addr;
  assign wr_cnt  = reg_we &&  reg_addr;

  tt_prescaler #(.PRESCALE(PRESCALE)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  tt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctrl),
    .wr_data (reg_wdata),
    .hit     (hit),
    .ctrl_q  (ctrl_q),
    .run     (run)
  );

  tt_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .mode    (ctrl_q.mode),
    .period  (ctrl_q.period),
    .wr_en   (wr_cnt),
    .wr_data (reg_wdata),
    .cnt_q   (cnt_q),
    .hit     (hit)
  );

  assign reg_rdata = reg_addr ? cnt_q : REG_W'(ctrl_q);
  assign irq       = ctrl_q.pend & ctrl_q.ie;
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tt_pkg::*;
#(
  parameter int PRESCALE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_ctrl,
  input  logic              wr_cnt,
  input  logic [REG_W-1:0]  reg_wdata,
  input  tm_ctrl_t          ctrl_q,
  input  logic [REG_W-1:0]  cnt_q
);
  logic [31:0] gap;
  logic [REG_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap <= '0;
    else if (tick) gap <= '0;
    else           gap <= gap + 1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap == 32'(PRESCALE - 1));  // R2

  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(reg_wdata));  // R11

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mode == TM_OFF && !wr_cnt) |=> $stable(cnt_q));  // R10

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && ctrl_q.mode == TM_RESTART &&
     cnt_inc[PER_W-1:0] == ctrl_q.period) |=> cnt_q == '0);  // R7

  AST_PEND_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.pend) |-> $past(ctrl_q.ie));  // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.pend) |-> $past(wr_ctrl && !reg_wdata[PER_W]));  // R6
endmodule

bind tick_timer tt_checker #(.PRESCALE(PRESCALE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_ctrl   (wr_ctrl),
  .wr_cnt    (wr_cnt),
  .reg_wdata (reg_wdata),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam int P = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  tick_timer #(.PRESCALE(P)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string phase = "R1 reset";

  // reference state, built from the requirements
  logic [31:0] m_ctrl, m_cnt;
  logic        m_halt;
  int          ecnt;

  function automatic logic [31:0] mw(logic [1:0] md, logic ie, logic pd, logic [27:0] per);
    return {md, ie, pd, per};
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic model_edge(logic we, logic a, logic [31:0] d);
    logic        tk, run, hit;
    logic [31:0] nx, nc, nm;
    logic        nh;
    tk  = (ecnt % P) == P - 1;
    run = (m_ctrl[31:30] != 2'b00) && !m_halt;
    nx  = m_cnt + 1;
    hit = tk && run && !(we && a) && (nx[27:0] == m_ctrl[27:0]);
    nc = m_cnt; nm = m_ctrl; nh = m_halt;
    if (we && a)      nc = d;
    else if (tk && run) nc = (hit && m_ctrl[31:30] == 2'b01) ? 32'h0 : nx;
    if (we && !a) begin
      nm = d; nm[28] = d[28] & m_ctrl[28]; nh = 1'b0;
    end else if (hit && m_ctrl[31:30] == 2'b10) begin
      nh = 1'b1;
    end
    if (hit && m_ctrl[29]) nm[28] = 1'b1;
    m_cnt = nc; m_ctrl = nm; m_halt = nh;
    ecnt++;
  endtask

  // called at a falling edge: check state, drive inputs, take one rising edge
  task automatic step(logic we, logic a, logic [31:0] d);
    reg_we = 1'b0; reg_addr = 1'b0;
    #0.5 chk(reg_rdata, m_ctrl, "control");
    reg_addr = 1'b1;
    #0.5 chk(reg_rdata, m_cnt, "count");
    chk({31'b0, irq}, {31'b0, m_ctrl[29] & m_ctrl[28]}, "irq");
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_ctrl = '0; m_cnt = '0; m_halt = 1'b0; ecnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    phase = "R1 reset";            step(1'b0, 1'b0, 32'h0);
    phase = "R3 port";             step(1'b1, 1'b0, mw(2'b11, 1'b1, 1'b1, 28'd5));
    phase = "R2 count";            idle(10);
    phase = "R5 pending";          idle(14);
    phase = "R6 clear";            step(1'b1, 1'b0, mw(2'b11, 1'b1, 1'b0, 28'd5));
    idle(3);
    // slide the clearing write across every phase around a hit
    phase = "R6 collision";
    for (int off = 0; off < 2 * P + 1; off++) begin
      step(1'b1, 1'b1, 32'd3);
      step(1'b1, 1'b0, mw(2'b11, 1'b1, 1'b0, 28'd5));
      idle(off);
      step(1'b1, 1'b0, mw(2'b11, 1'b1, 1'b0, 28'd5));
      idle(2 * P);
    end
    phase = "R7 restart";          step(1'b1, 1'b0, mw(2'b01, 1'b1, 1'b0, 28'd4));
    step(1'b1, 1'b1, 32'h0);
    idle(40);
    phase = "R8 oneshot";          step(1'b1, 1'b0, mw(2'b10, 1'b1, 1'b0, 28'd3));
    step(1'b1, 1'b1, 32'h0);
    idle(30);
    step(1'b1, 1'b0, mw(2'b10, 1'b0, 1'b0, 28'd9));
    idle(40);
    phase = "R10 off";             step(1'b1, 1'b0, mw(2'b00, 1'b1, 1'b0, 28'd5));
    step(1'b1, 1'b1, 32'd4);
    idle(20);
    phase = "R9 wrap";             step(1'b1, 1'b0, mw(2'b11, 1'b1, 1'b0, 28'd0));
    step(1'b1, 1'b1, 32'h0FFF_FFFD);
    idle(24);
    phase = "R4 upper bits";       step(1'b1, 1'b0, mw(2'b01, 1'b1, 1'b0, 28'd4));
    step(1'b1, 1'b1, 32'hA000_0001);
    idle(30);
    phase = "R11 write wins";      step(1'b1, 1'b0, mw(2'b01, 1'b1, 1'b0, 28'd4));
    for (int i = 0; i < 4 * P; i++) step(1'b1, 1'b1, 32'd3);
    idle(2);
    phase = "R11 mixed";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) begin
        if (r[3]) step(1'b1, 1'b1, {r[31:28], 21'b0, r[6:4]} & 32'hF000_0007);
        else      step(1'b1, 1'b0, mw(r[31:30], r[29], r[28], {25'b0, r[10:8]}));
      end else begin
        step(1'b0, 1'b0, 32'h0);
      end
    end
    finish_run();
  end
endmodule